// File: doc/BRIEF.md
# Multi-Mode Waveform Timer Counter

This block is an 8-bit counter that advances only in system-clock cycles where a timer-tick enable is high. A 2-bit mode input chooses how the count moves: a free-running wrap, a clear-on-compare period whose top is the compare value, a single-slope PWM ramp, or a dual-slope PWM triangle. The block holds the count, the slope direction and a compare value that is double-buffered in the PWM modes. It keeps two sticky event flags (overflow and compare), each cleared by a write-one pulse.

Software-side writes arrive as two load strobes that share one data bus. One strobe loads the count and the other loads the compare value. The block exports a compare-match strobe and the slope direction, so that a separate waveform stage can set or clear an output pin. That stage is not part of this block.

Top module: `wavetimer_core`

## Requirements
- R1: After reset the count is 0, the active compare value is 0, `down` is 0 and both flags are 0.
- R2: In mode 0 (free run) and mode 3 (single-slope PWM), each tick adds one to the count, and a tick at 255 gives 0, so zero recurs every 256 ticks. Without a tick or a count write the count holds in every mode.
- R3: In modes 0, 2 and 3, a tick taken while the count is 255 sets the overflow flag in the following cycle.
- R4: In mode 2 (clear on compare), a tick taken while the count equals the active compare value makes the next count 0. With compare value C, zero recurs every C+1 ticks.
- R5: In mode 1 (dual-slope PWM), the count rises from 0 to 255 and then falls to 0, showing 255 and 0 once each, for a period of 510 ticks. `down` is 1 from the cycle after 255 up to and including the cycle the count shows 0.
- R6: In mode 1, a tick taken while the count is 0 sets the overflow flag; a tick at 255 does not.
- R7: `match_stb` is high in a cycle with a tick, no count write, and a count equal to the active compare value. The compare flag sets in the following cycle.
- R8: In modes 0 and 2, a compare write updates the active compare value in the next cycle.
- R9: In modes 1 and 3, a compare write goes only to a buffer. The active value takes the buffer on a tick at count 255; a write in that same cycle lands in the buffer and is used at the next 255.
- R10: A count write loads the data in the next cycle and overrides the tick. The tick in that cycle makes no match strobe, sets no flag, causes no buffer transfer and no direction change.
- R11: A flag clear pulse zeroes its flag in the next cycle unless a set event occurs in the same cycle; the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer-clock enable; qualifies every count step and flag event |
| mode | input | 2 | 0 free run, 1 dual-slope PWM, 2 clear on compare, 3 single-slope PWM |
| wr_cnt | input | 1 | Load the count from `wr_data` |
| wr_cmp | input | 1 | Write `wr_data` as the compare value |
| wr_data | input | 8 | Shared write data |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| cmp_clr | input | 1 | Write-one clear of the compare flag |
| count | output | 8 | Current count |
| cmp_val | output | 8 | Active compare value |
| down | output | 1 | 1 while the dual-slope count is falling |
| match_stb | output | 1 | Compare-match strobe for the waveform stage |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
A wrong count or direction bit is visible on `count` and `down` at the next tick, and every later step inherits the error. A wrong active compare value shows on `cmp_val` directly. It also moves the `match_stb` cycle and the compare flag, and in mode 2 it changes the period. The bench runs a cycle-level reference model and compares every output after each edge in all four modes, with idle gaps, mid-run writes and flag clears. A bad buffer transfer in a PWM mode therefore shows on `cmp_val` within one ramp. Separate period measurements confirm the 256, C+1 and 510 tick spacing of zero crossings.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_DUAL = 2'd1,
        MODE_CLR  = 2'd2,
        MODE_FAST = 2'd3
    } wave_mode_e;

    // PWM modes use the double-buffered compare value
    function automatic logic is_buffered(input wave_mode_e m);
        return (m == MODE_DUAL) || (m == MODE_FAST);
    endfunction
endpackage

// File: rtl/wtc_step.sv
module wtc_step
    import wtc_pkg::*;
#(
    parameter int W = 8
) (
    input  wave_mode_e     mode,
    input  logic [W-1:0]   cnt,
    input  logic           dir,
    input  logic [W-1:0]   cmp,
    output logic [W-1:0]   cnt_n,
    output logic           dir_n
);
    localparam logic [W-1:0] TOP_FULL = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        dir_n = 1'b0;
        cnt_n = cnt + ONE;
        case (mode)
            MODE_DUAL: begin
                if (cnt == TOP_FULL)  dir_n = 1'b1;
                else if (cnt == '0)   dir_n = 1'b0;
                else                  dir_n = dir;
                cnt_n = dir_n ? (cnt - ONE) : (cnt + ONE);
            end
            MODE_CLR: begin
                cnt_n = (cnt == cmp) ? '0 : (cnt + ONE);
            end
            default: begin
                cnt_n = cnt + ONE;
            end
        endcase
    end
endmodule

// File: rtl/wtc_cmp_unit.sv
module wtc_cmp_unit
    import wtc_pkg::*;
#(
    parameter int W = 8
) (
    input  wave_mode_e     mode,
    input  logic           wr_cmp,
    input  logic [W-1:0]   wr_data,
    input  logic           at_top_ev,
    input  logic [W-1:0]   act_q,
    input  logic [W-1:0]   shadow_q,
    output logic [W-1:0]   act_d,
    output logic [W-1:0]   shadow_d
);
    always_comb begin
        shadow_d = wr_cmp ? wr_data : shadow_q;
        if (is_buffered(mode)) begin
            act_d = at_top_ev ? shadow_q : act_q;
        end else begin
            act_d = wr_cmp ? wr_data : act_q;
        end
    end
endmodule

// File: rtl/wtc_flag_next.sv
module wtc_flag_next (
    input  logic flag_q,
    input  logic set_ev,
    input  logic clr,
    output logic flag_d
);
    always_comb flag_d = set_ev | (flag_q & ~clr);
endmodule

// File: rtl/wavetimer_core.sv
module wavetimer_core
    import wtc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [1:0]     mode,
    input  logic           wr_cnt,
    input  logic           wr_cmp,
    input  logic [W-1:0]   wr_data,
    input  logic           ovf_clr,
    input  logic           cmp_clr,
    output logic [W-1:0]   count,
    output logic [W-1:0]   cmp_val,
    output logic           down,
    output logic           match_stb,
    output logic           ovf_flag,
    output logic           cmp_flag
);
    localparam logic [W-1:0] TOP_FULL = {W{1'b1}};
    localparam int           NFLAG    = 2;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir;
        logic [W-1:0] act;
        logic [W-1:0] shadow;
        logic [NFLAG-1:0] flg;
    } state_t;

    state_t     s_q, s_d;
    wave_mode_e mode_e;
    logic       step_ev;
    logic [W-1:0] step_cnt;
    logic       step_dir;
    logic [W-1:0] act_d, shadow_d;
    logic [NFLAG-1:0] flg_set, flg_clr, flg_d;

    assign mode_e  = wave_mode_e'(mode);
    assign step_ev = tick & ~wr_cnt;

    wtc_step #(.W(W)) u_step (
        .mode  (mode_e),
        .cnt   (s_q.cnt),
        .dir   (s_q.dir),
        .cmp   (s_q.act),
        .cnt_n (step_cnt),
        .dir_n (step_dir)
    );

    wtc_cmp_unit #(.W(W)) u_cmp (
        .mode      (mode_e),
        .wr_cmp    (wr_cmp),
        .wr_data   (wr_data),
        .at_top_ev (step_ev && (s_q.cnt == TOP_FULL)),
        .act_q     (s_q.act),
        .shadow_q  (s_q.shadow),
        .act_d     (act_d),
        .shadow_d  (shadow_d)
    );

    // flag 0: overflow, flag 1: compare
    assign flg_set[0] = step_ev && ((mode_e == MODE_DUAL) ? (s_q.cnt == '0)
                                                          : (s_q.cnt == TOP_FULL));
    assign flg_set[1] = step_ev && (s_q.cnt == s_q.act);
    assign flg_clr    = {cmp_clr, ovf_clr};

    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_flag
            wtc_flag_next u_flag (
                .flag_q (s_q.flg[g]),
                .set_ev (flg_set[g]),
                .clr    (flg_clr[g]),
                .flag_d (flg_d[g])
            );
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.act    = act_d;
        s_d.shadow = shadow_d;
        s_d.flg    = flg_d;
        if (wr_cnt) begin
            s_d.cnt = wr_data;
        end else if (tick) begin
            s_d.cnt = step_cnt;
            s_d.dir = step_dir;
        end
        if (mode_e != MODE_DUAL) s_d.dir = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count     = s_q.cnt;
    assign cmp_val   = s_q.act;
    assign down      = s_q.dir;
    assign match_stb = flg_set[1];
    assign ovf_flag  = s_q.flg[0];
    assign cmp_flag  = s_q.flg[1];
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [1:0]   mode,
    input logic         wr_cnt,
    input logic [W-1:0] count,
    input logic [W-1:0] cmp_val,
    input logic         match_stb,
    input logic         ovf_flag,
    input logic         ovf_clr,
    input logic         cmp_flag
);
    localparam logic [W-1:0] TOPV = {W{1'b1}};

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(count));

    a_r4_clear_at_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode == 2'd2 && count == cmp_val) |=> (count == '0));

    a_r5_bottom_turns_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode == 2'd1 && count == '0) |=> (count == {{(W-1){1'b0}}, 1'b1}));

    a_r7_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_stb |=> cmp_flag);

    a_r9_buffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[0] && !(tick && !wr_cnt && count == TOPV)) |=> $stable(cmp_val));

    a_r10_write_blocks_match: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |-> !match_stb);

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind wavetimer_core wtc_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (mode),
    .wr_cnt    (wr_cnt),
    .count     (count),
    .cmp_val   (cmp_val),
    .match_stb (match_stb),
    .ovf_flag  (ovf_flag),
    .ovf_clr   (ovf_clr),
    .cmp_flag  (cmp_flag)
);

// File: tb/sim_wavetimer_core.sv
module sim_wavetimer_core;
    localparam int W = 8;
    localparam logic [W-1:0] MX = {W{1'b1}};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, tick, wr_cnt, wr_cmp, ovf_clr, cmp_clr;
    logic [1:0] mode;
    logic [W-1:0] wr_data, count, cmp_val;
    logic down, match_stb, ovf_flag, cmp_flag;

    wavetimer_core #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .wr_cnt(wr_cnt), .wr_cmp(wr_cmp), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
        .count(count), .cmp_val(cmp_val), .down(down),
        .match_stb(match_stb), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    int checks = 0;
    int fails  = 0;
    int ncyc   = 0;

    logic [W-1:0] m_cnt, m_cmp, m_buf;
    logic m_dir, m_ovf, m_cf;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, ncyc);
        end
    endtask

    // one clock: drive after negedge, check strobe, then check registered outputs
    task automatic cyc(input logic t, input logic wc, input logic wm,
                       input logic [W-1:0] d, input logic oc, input logic cc);
        logic ev, em, eo, nd;
        logic [W-1:0] nc, nm, nb;
        string ctag;
        tick = t; wr_cnt = wc; wr_cmp = wm; wr_data = d; ovf_clr = oc; cmp_clr = cc;
        #1;
        ev = t && !wc;
        em = ev && (m_cnt == m_cmp);
        chk(wc ? "R10 match_stb" : "R7 match_stb", match_stb, em);
        nc = m_cnt; nd = m_dir;
        if (ev) begin
            case (mode)
                2'd1: begin
                    nd = (m_cnt == MX) ? 1'b1 : (m_cnt == '0) ? 1'b0 : m_dir;
                    nc = nd ? m_cnt - 1'b1 : m_cnt + 1'b1;
                end
                2'd2: nc = (m_cnt == m_cmp) ? '0 : m_cnt + 1'b1;
                default: nc = m_cnt + 1'b1;
            endcase
        end
        if (wc) nc = d;
        if (mode != 2'd1) nd = 1'b0;
        eo = ev && ((mode == 2'd1) ? (m_cnt == '0) : (m_cnt == MX));
        nb = wm ? d : m_buf;
        if (mode[0]) nm = (ev && m_cnt == MX) ? m_buf : m_cmp;
        else         nm = wm ? d : m_cmp;
        @(posedge clk);
        #1;
        ncyc++;
        m_cnt = nc; m_dir = nd; m_cmp = nm; m_buf = nb;
        m_ovf = eo | (m_ovf & !oc);
        m_cf  = em | (m_cf & !cc);
        case (mode)
            2'd1: ctag = "R5 count";
            2'd2: ctag = "R4 count";
            default: ctag = "R2 count";
        endcase
        if (wc) ctag = "R10 count";
        chk(ctag, count, m_cnt);
        chk("R5 down", down, m_dir);
        chk(mode[0] ? "R9 cmp_val" : "R8 cmp_val", cmp_val, m_cmp);
        chk(oc ? "R11 ovf_flag" : (mode == 2'd1 ? "R6 ovf_flag" : "R3 ovf_flag"), ovf_flag, m_ovf);
        chk(cc ? "R11 cmp_flag" : "R7 cmp_flag", cmp_flag, m_cf);
        @(negedge clk);
    endtask

    // ticks between the first two cycles that show count zero
    task automatic measure_gap(input int exp_gap, input string tag);
        int first = -1;
        int gap = -1;
        for (int i = 0; i < 1200 && gap < 0; i++) begin
            cyc(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1);
            if (count == '0) begin
                if (first < 0) first = i;
                else gap = i - first;
            end
        end
        chk(tag, gap, exp_gap);
    endtask

    task automatic sweep(input logic [1:0] md, input logic [W-1:0] c0, input logic [W-1:0] c1, input int n);
        mode = md;
        cyc(1'b0, 1'b0, 1'b1, c0, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            logic t, wc, wm, oc, cc;
            logic [W-1:0] d;
            t  = (i % 5) != 3;
            wc = (i == 400) || (i == 700);
            wm = (i == 200) || (i == 900);
            d  = wc ? ((i == 400) ? c1 : 8'hF0) : c1 ^ 8'h11;
            if (i == 200) d = c1;
            oc = (i % 97) == 50;
            cc = (i % 61) == 30;
            cyc(t, wc, wm, d, oc, cc);
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 0; wr_cnt = 0; wr_cmp = 0; wr_data = '0;
        ovf_clr = 0; cmp_clr = 0; mode = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 count", count, '0);
        chk("R1 cmp_val", cmp_val, '0);
        chk("R1 down", down, 1'b0);
        chk("R1 ovf_flag", ovf_flag, 1'b0);
        chk("R1 cmp_flag", cmp_flag, 1'b0);
        m_cnt = '0; m_cmp = '0; m_buf = '0; m_dir = 0; m_ovf = 0; m_cf = 0;

        sweep(2'd0, 8'h40, 8'h90, 1200);
        sweep(2'd2, 8'h30, 8'h18, 1200);
        sweep(2'd3, 8'h80, 8'h20, 1200);
        sweep(2'd1, 8'h60, 8'hC0, 1500);

        // R10: count write while count equals compare, with tick
        mode = 2'd0;
        cyc(1'b0, 1'b0, 1'b1, 8'h22, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 8'h22, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0);
        chk("R10 no compare flag", cmp_flag, 1'b0);

        // R11: clear and set in the same cycle, set wins
        cyc(1'b0, 1'b1, 1'b0, MX, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b0);
        chk("R11 set wins", ovf_flag, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
        chk("R11 cleared", ovf_flag, 1'b0);

        // period measurements
        mode = 2'd3;
        measure_gap(256, "R2 fast period");
        mode = 2'd2;
        cyc(1'b0, 1'b0, 1'b1, 8'd9, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 8'd1, 1'b0, 1'b0);
        measure_gap(10, "R4 clear period");
        mode = 2'd1;
        measure_gap(510, "R5 dual period");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule